// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides whether a logical address falls inside one of a small set of programmable pass-through windows. Each window is a 32-bit control word holding an upper-byte address base, a per-bit don't-care mask over that byte, an enable, a privilege selector, a write-protect bit and a two-bit cache attribute. When a lookup lands inside an enabled window, the address is used unchanged as the physical address and the response carries the permissions that the window grants. A translation unit would consult it before walking page tables.

Windows come in two classes: the lower half of the index space serves instruction fetches and the upper half serves data accesses. Lookups enter on a valid/ready request channel and return on a valid/ready response channel, one response per accepted request. A plain write port loads window control words.

Top module: `ttw_matcher`

## Requirements
- R1: After reset every window is disabled, `rsp_valid` is low and `req_ready` is high, so the first lookup misses.
- R2: A window with bit 15 of its control word clear never hits.
- R3: Control bits 14:13 select privilege: 00 hits only when `req_super` is 0, 01 hits only when `req_super` is 1, and 10 or 11 hit for either.
- R4: Only address bits 31:24 are compared, against control bits 31:24; a set bit i of control bits 23:16 makes address bit 24+i a don't-care, and address bits 23:0 never affect the hit.
- R5: A hit sets `rsp_rd` and `rsp_ex`; `rsp_wr` is set on a hit only when control bit 2 (write protect) is 0. A miss clears all three.
- R6: A request with `req_code` 1 consults only windows 0 to N-1; with `req_code` 0 only windows N to 2N-1 (N = `WIN_PER_CLASS`, 2 by default).
- R7: When several eligible windows hit, the lowest index wins and is reported on `rsp_idx`; `rsp_idx` is 0 on a miss.
- R8: On a hit `rsp_phys` equals the request address and `rsp_cmode` equals control bits 6:5 of the winning window; on a miss both are 0.
- R9: `rsp_tt` and `rsp_res` are both 1 exactly when the request had `req_probe` set and hit; otherwise both are 0.
- R10: `rsp_wfault` is 1 exactly when a store (`req_store` 1) hits a write-protected window.
- R11: `req_ready` is high when `rsp_valid` is low or `rsp_ready` is high; the response to a request accepted at an edge appears at that edge, and a response not taken (`rsp_ready` low) holds all its fields unchanged.
- R12: A control-word write is seen by requests accepted after the writing edge; a request accepted at the same edge uses the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_idx | input | IDX_W | Window index written |
| wr_data | input | 32 | Control word value |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high with req_valid |
| req_addr | input | 32 | Logical address |
| req_code | input | 1 | 1 for instruction fetch, 0 for data |
| req_super | input | 1 | 1 for supervisor access |
| req_store | input | 1 | 1 for a store |
| req_probe | input | 1 | 1 for a test probe |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | A window matched |
| rsp_idx | output | IDX_W | Index of the winning window |
| rsp_phys | output | 32 | Pass-through physical address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| rsp_wfault | output | 1 | Store hit a write-protected window |
| rsp_cmode | output | 2 | Cache attribute of the winning window |
| rsp_tt | output | 1 | Probe status: transparent |
| rsp_res | output | 1 | Probe status: resident |

## Verification
Every response is due one clock edge after its request is accepted, so the bench drives a request on a falling edge, lets one rising edge accept it, and reads the response on the following falling edge. A control-word write becomes visible to requests accepted one edge later, which the bench exercises by issuing a write and a lookup in the same cycle and expecting the old result, then the new one on the next lookup. Back-pressure is checked by holding `rsp_ready` low for several cycles and reading the frozen response and the low `req_ready` on falling edges between them.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned FIELD_W  = 8;
  // control word field positions
  localparam int unsigned BASE_LSB = 24;
  localparam int unsigned MASK_LSB = 16;
  localparam int unsigned EN_BIT   = 15;
  localparam int unsigned PRIV_LSB = 13;
  localparam int unsigned CM_LSB   = 5;
  localparam int unsigned WP_BIT   = 2;
  localparam int unsigned CM_W     = 2;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_ANY_A = 2'b10,
    PRIV_ANY_B = 2'b11
  } priv_sel_e;
endpackage

// File: rtl/ttw_winreg_bank.sv
module ttw_winreg_bank
  import ttw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] win_q [NUM_WIN]
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n)
        win_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        win_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/ttw_window_cmp.sv
module ttw_window_cmp
  import ttw_pkg::*;
(
  input  logic [WORD_W-1:0]  win_word,
  input  logic [FIELD_W-1:0] addr_hi,
  input  logic               is_super,
  output logic               hit,
  output logic               wprot,
  output logic [CM_W-1:0]    cmode
);
  logic [FIELD_W-1:0] care;
  logic               priv_ok;
  logic [11:0]        unused_fields;

  assign unused_fields = {win_word[12:7], win_word[4:3], win_word[1:0], 2'b00};

  always_comb begin
    unique case (priv_sel_e'(win_word[PRIV_LSB +: 2]))
      PRIV_USER:  priv_ok = !is_super;
      PRIV_SUPER: priv_ok = is_super;
      default:    priv_ok = 1'b1;
    endcase
  end

  // set mask bits mean "ignore", so the care set is the inverse
  assign care  = ~win_word[MASK_LSB +: FIELD_W];
  assign hit   = win_word[EN_BIT] && priv_ok &&
                 ((addr_hi & care) == (win_word[BASE_LSB +: FIELD_W] & care));
  assign wprot = win_word[WP_BIT];
  assign cmode = win_word[CM_LSB +: CM_W];
endmodule

// File: rtl/ttw_prio_pick.sv
module ttw_prio_pick #(
  parameter int unsigned NUM_WIN = 4,
  localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0] hit_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   first_idx
);
  always_comb begin
    any_hit   = 1'b0;
    first_idx = '0;
    // scan downward so the lowest set index is the last one assigned
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit   = 1'b1;
        first_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ttw_matcher.sv
module ttw_matcher
  import ttw_pkg::*;
#(
  parameter int unsigned WIN_PER_CLASS = 2,
  localparam int unsigned NUM_WIN = 2 * WIN_PER_CLASS,
  localparam int unsigned IDX_W   = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_code,
  input  logic              req_super,
  input  logic              req_store,
  input  logic              req_probe,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [ADDR_W-1:0] rsp_phys,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic              rsp_ex,
  output logic              rsp_wfault,
  output logic [CM_W-1:0]   rsp_cmode,
  output logic              rsp_tt,
  output logic              rsp_res
);
  logic [WORD_W-1:0]  win_q   [NUM_WIN];
  logic [CM_W-1:0]    cm_arr  [NUM_WIN];
  logic [NUM_WIN-1:0] raw_hit;
  logic [NUM_WIN-1:0] elig;
  logic [NUM_WIN-1:0] wp_vec;
  logic               sel_hit;
  logic [IDX_W-1:0]   sel_idx;
  logic               sel_wp;

  ttw_winreg_bank #(.NUM_WIN(NUM_WIN)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .win_q   (win_q)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    ttw_window_cmp u_cmp (
      .win_word (win_q[g]),
      .addr_hi  (req_addr[BASE_LSB +: FIELD_W]),
      .is_super (req_super),
      .hit      (raw_hit[g]),
      .wprot    (wp_vec[g]),
      .cmode    (cm_arr[g])
    );
    if (g < WIN_PER_CLASS) begin : g_instr
      assign elig[g] = req_code;
    end else begin : g_data
      assign elig[g] = !req_code;
    end
  end

  ttw_prio_pick #(.NUM_WIN(NUM_WIN)) u_pick (
    .hit_vec   (raw_hit & elig),
    .any_hit   (sel_hit),
    .first_idx (sel_idx)
  );

  assign sel_wp    = wp_vec[sel_idx];
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_idx    <= '0;
      rsp_phys   <= '0;
      rsp_rd     <= 1'b0;
      rsp_wr     <= 1'b0;
      rsp_ex     <= 1'b0;
      rsp_wfault <= 1'b0;
      rsp_cmode  <= '0;
      rsp_tt     <= 1'b0;
      rsp_res    <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= sel_hit;
        rsp_idx    <= sel_hit ? sel_idx : '0;
        rsp_phys   <= sel_hit ? req_addr : '0;
        rsp_rd     <= sel_hit;
        rsp_ex     <= sel_hit;
        rsp_wr     <= sel_hit && !sel_wp;
        rsp_wfault <= sel_hit && sel_wp && req_store;
        rsp_cmode  <= sel_hit ? cm_arr[sel_idx] : '0;
        rsp_tt     <= sel_hit && req_probe;
        rsp_res    <= sel_hit && req_probe;
      end
    end
  end
endmodule

// File: rtl/ttw_matcher_chk.sv
module ttw_matcher_chk
  import ttw_pkg::*;
#(
  parameter int unsigned WIN_PER_CLASS = 2,
  localparam int unsigned NUM_WIN = 2 * WIN_PER_CLASS,
  localparam int unsigned IDX_W   = $clog2(NUM_WIN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_code,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [IDX_W-1:0]  rsp_idx,
  input logic [ADDR_W-1:0] rsp_phys,
  input logic              rsp_rd,
  input logic              rsp_wr,
  input logic              rsp_ex,
  input logic              rsp_wfault,
  input logic              rsp_tt,
  input logic              rsp_res
);
  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_phys) &&
                                   $stable(rsp_idx) && $stable(rsp_hit)));

  p_hit_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_rd && rsp_ex));

  p_miss_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_rd && !rsp_wr && !rsp_ex && rsp_phys == '0));

  p_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (!rsp_hit || ((rsp_idx < IDX_W'(WIN_PER_CLASS)) == $past(req_code))));

  p_phys_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!rsp_hit || rsp_phys == $past(req_addr)));

  p_probe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_tt || rsp_res)) |-> (rsp_hit && rsp_tt && rsp_res));

  p_wfault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wfault) |-> (rsp_hit && !rsp_wr));
endmodule

bind ttw_matcher ttw_matcher_chk #(.WIN_PER_CLASS(WIN_PER_CLASS)) u_chk (.*);

// File: tb/ttw_matcher_test.sv
`timescale 1ns/1ps
module ttw_matcher_test;
  localparam int unsigned IDX_W = 2;

  typedef struct packed {
    logic        code;
    logic        sup;
    logic        st;
    logic        pr;
    logic [31:0] addr;
    logic        hit;
    logic [1:0]  idx;
    logic        wr;
    logic [1:0]  cm;
    logic        wf;
  } vec_t;

  // window words: base[31:24] mask[23:16] en[15] priv[14:13] cm[6:5] wp[2]
  localparam logic [31:0] W0 = 32'h100FA020; // base 10 ign low nibble, super only, cm 01
  localparam logic [31:0] W1 = 32'h1200C064; // base 12 exact, either, wp, cm 11
  localparam logic [31:0] W2 = 32'h8000E040; // base 80 exact, either (11), cm 10
  localparam logic [31:0] W3 = 32'h12F08004; // base x2, user only, wp, cm 00

  localparam int NV = 16;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1,1'b1,1'b0,1'b0,32'h12345678,1'b1,2'd0,1'b1,2'b01,1'b0}, // R7 both hit, 0 wins
    '{1'b1,1'b0,1'b0,1'b0,32'h12345678,1'b1,2'd1,1'b0,2'b11,1'b0}, // R3 R5 user skips 0
    '{1'b1,1'b1,1'b0,1'b0,32'h1F000000,1'b1,2'd0,1'b1,2'b01,1'b0}, // R4 masked bits
    '{1'b1,1'b1,1'b0,1'b0,32'h20000000,1'b0,2'd0,1'b0,2'b00,1'b0}, // R4 cared bit differs
    '{1'b1,1'b0,1'b0,1'b0,32'h15000000,1'b0,2'd0,1'b0,2'b00,1'b0}, // R3 super-only window
    '{1'b0,1'b0,1'b0,1'b0,32'h80001234,1'b1,2'd2,1'b1,2'b10,1'b0}, // R6 R8 data window
    '{1'b0,1'b1,1'b1,1'b0,32'h80ABCDEF,1'b1,2'd2,1'b1,2'b10,1'b0}, // R10 store, no wp
    '{1'b0,1'b0,1'b0,1'b0,32'h12000000,1'b1,2'd3,1'b0,2'b00,1'b0}, // R4 R5 high nibble ignored
    '{1'b0,1'b0,1'b1,1'b0,32'hA2FFFFFF,1'b1,2'd3,1'b0,2'b00,1'b1}, // R10 store to wp
    '{1'b0,1'b1,1'b0,1'b0,32'h12000000,1'b0,2'd0,1'b0,2'b00,1'b0}, // R3 user-only window
    '{1'b0,1'b0,1'b0,1'b0,32'h13000000,1'b0,2'd0,1'b0,2'b00,1'b0}, // R4 miss
    '{1'b1,1'b0,1'b0,1'b0,32'h80000000,1'b0,2'd0,1'b0,2'b00,1'b0}, // R6 code skips data
    '{1'b0,1'b1,1'b0,1'b0,32'h10000000,1'b0,2'd0,1'b0,2'b00,1'b0}, // R6 data skips code
    '{1'b0,1'b0,1'b0,1'b1,32'h80000000,1'b1,2'd2,1'b1,2'b10,1'b0}, // R9 probe hit
    '{1'b0,1'b0,1'b0,1'b1,32'h13000000,1'b0,2'd0,1'b0,2'b00,1'b0}, // R9 probe miss
    '{1'b1,1'b1,1'b0,1'b1,32'h1A000000,1'b1,2'd0,1'b1,2'b01,1'b0}  // R9 R8 code probe
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [31:0]       wr_data = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [31:0]       req_addr = '0;
  logic              req_code = 1'b0;
  logic              req_super = 1'b0;
  logic              req_store = 1'b0;
  logic              req_probe = 1'b0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic              rsp_hit;
  logic [IDX_W-1:0]  rsp_idx;
  logic [31:0]       rsp_phys;
  logic              rsp_rd, rsp_wr, rsp_ex, rsp_wfault, rsp_tt, rsp_res;
  logic [1:0]        rsp_cmode;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ttw_matcher uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [42:0] pack_rsp();
    return {rsp_hit, rsp_idx, rsp_rd, rsp_wr, rsp_ex, rsp_wfault,
            rsp_cmode, rsp_tt, rsp_res, rsp_phys};
  endfunction

  function automatic logic [42:0] pack_exp(input vec_t v);
    return {v.hit, v.idx, v.hit, v.wr, v.hit, v.wf, v.cm,
            v.hit & v.pr, v.hit & v.pr, v.hit ? v.addr : 32'h0};
  endfunction

  task automatic write_win(input logic [1:0] idx, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drive at a falling edge, accepted at the next rising edge,
  // response read at the falling edge after that
  task automatic lookup(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_code = v.code; req_super = v.sup;
    req_store = v.st; req_probe = v.pr; req_addr = v.addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    vec_t t;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R1 req_ready", {63'd0, req_ready}, 64'd1);
    t = '{1'b0,1'b0,1'b0,1'b0,32'h80000000,1'b0,2'd0,1'b0,2'b00,1'b0};
    lookup(t);
    check("R1 miss after reset", {21'd0, pack_rsp()}, {21'd0, pack_exp(t)});

    write_win(2'd0, W0);
    write_win(2'd1, W1);
    write_win(2'd2, W2);
    write_win(2'd3, W3);

    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i]);
      check($sformatf("vector %0d", i), {20'd0, rsp_valid, pack_rsp()},
            {20'd0, 1'b1, pack_exp(VEC[i])});
    end

    // R2 enable cleared
    write_win(2'd2, 32'h80006040);
    t = '{1'b0,1'b0,1'b0,1'b0,32'h80000000,1'b0,2'd0,1'b0,2'b00,1'b0};
    lookup(t);
    check("R2 disabled window", {21'd0, pack_rsp()}, {21'd0, pack_exp(t)});

    // R12 write and lookup at the same edge see the old word
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'd2; wr_data = W2;
    req_valid = 1'b1; req_code = 1'b0; req_super = 1'b0;
    req_store = 1'b0; req_probe = 1'b0; req_addr = 32'h80000000;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R12 same-edge old word", {63'd0, rsp_hit}, 64'd0);
    t = '{1'b0,1'b0,1'b0,1'b0,32'h80000000,1'b1,2'd2,1'b1,2'b10,1'b0};
    lookup(t);
    check("R12 next lookup new word", {21'd0, pack_rsp()}, {21'd0, pack_exp(t)});

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_code = 1'b0; req_addr = 32'h80000010;
    @(negedge clk);
    check("R11 valid under stall", {63'd0, rsp_valid}, 64'd1);
    check("R11 ready low under stall", {63'd0, req_ready}, 64'd0);
    held = rsp_phys;
    req_addr = 32'h80000020;
    repeat (3) @(negedge clk);
    check("R11 response held", {32'd0, rsp_phys}, {32'd0, held});
    check("R11 held value", {32'd0, held}, 64'h80000010);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 next response", {32'd0, rsp_phys}, 64'h80000020);
    @(negedge clk);
    check("R11 drained", {63'd0, rsp_valid}, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule